// File: doc/BRIEF.md
# Multi-frame configurable-length SPI transfer engine

This block moves one SPI transfer of one to four frames. Each frame has a length taken from a fixed set between 8 and 32 bits. As master it generates the serial clock, the data output and an active-low select. As slave it follows an external clock and select, which pass through synchronizer flops. The select can be left out entirely in three-wire clock-synchronous operation. Data uses clock mode 0: each bit is launched on the falling clock edge and sampled on the rising edge.

Transmit data comes in through a 128-bit holding register. Accepting a start moves the holding register into the active register, so the next transfer's data can be written while the current one runs. Received bits build up in a shadow register. The whole 128-bit result moves to the `rx_data` output, together with a one-cycle `done` pulse, when the last bit of the last frame is complete. Frame k always occupies bits starting at 32·k, whatever its length.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for an accepted start.
- `ST_LEAD`: select low, clock low, first bit on the line.
- `ST_HIGH`: clock high.
- `ST_LOW`: clock low, next bit launched.
- `ST_TRAIL`: clock low before the select is released.
- `ST_SLAVE`: follows the external clock.

Its transitions are:
- `ST_IDLE`→`ST_LEAD` on an accepted start in master mode.
- `ST_IDLE`→`ST_SLAVE` on an accepted start in slave mode.
- `ST_LEAD`→`ST_HIGH` on a half-period tick.
- `ST_HIGH`→`ST_LOW` on a tick when bits remain.
- `ST_HIGH`→`ST_TRAIL` on a tick at the last bit.
- `ST_LOW`→`ST_HIGH` on a tick.
- `ST_TRAIL`→`ST_IDLE` on a tick, with `done` raised.
- `ST_SLAVE`→`ST_IDLE` on the enabled rising clock edge of the last bit, with `done` raised.

Top module: `spi_xfer_engine`

## Requirements
- R1: `cfg_len` codes 0..8 select frame lengths 8..16 bits, code 9 selects 20, code 10 selects 24 and code 11 selects 32. A start given with codes 12..15 is ignored: no clock, no select and no `done`.
- R2: Frame k sends and receives bits [32k+len-1 : 32k] of the 128-bit buffers. All other bits of `rx_data` read as zero after a transfer.
- R3: With `cfg_lsb`=1 each frame goes out and comes in least significant bit first. With `cfg_lsb`=0 it goes most significant bit first. Frames go in order 0, 1, 2, 3.
- R4: `cfg_nfr` holds the frame count minus one, so 0..3 gives 1..4 frames. A master transfer makes exactly frames·len rising clock edges.
- R5: As master, `sck_o` idles low and has a period of 2·(`half_div`+1) system clocks. `mosi_o` changes only on the falling edge of `sck_o`, and `miso_i` is sampled on the rising edge.
- R6: As master in four-wire mode (`cfg_3wire`=0), `ss_n_o` goes low half a period before the first rising clock edge and stays low through every edge. It goes high again half a period after the last edge. In three-wire mode `ss_n_o` stays high.
- R7: As slave (`cfg_master`=0), the block samples `mosi_i` on rising edges of `sck_i` and presents its transmit bits on `miso_o`. In four-wire mode, clock edges while `ss_n_i` is high are ignored.
- R8: `done` is a one-cycle pulse raised when the last frame is complete. `rx_data` holds the new result in the same cycle.
- R9: A write with `tx_wr` while the holding register is full leaves that register unchanged and sets `tx_overrun`, which stays set until reset. A start is accepted only while the holding register is full. Accepting a start empties the holding register, so a write during a transfer is accepted without overrun.
- R10: After reset, `sck_o`=0, `ss_n_o`=1, `done`=0, `tx_overrun`=0 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master, 0 = slave; latched at start |
| cfg_3wire | input | 1 | 1 = no select line; latched at start |
| cfg_lsb | input | 1 | 1 = LSB first; latched at start |
| cfg_len | input | 4 | Frame length code; latched at start |
| cfg_nfr | input | 2 | Frame count minus one; latched at start |
| half_div | input | 8 | Serial clock half-period minus one, in system clocks |
| tx_wr | input | 1 | Write `tx_data` into the holding register |
| tx_data | input | 128 | Transmit data for one transfer |
| start | input | 1 | Request a transfer |
| tx_overrun | output | 1 | Sticky flag: write while holding register full |
| rx_data | output | 128 | Received data of the last transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sck_o | output | 1 | Serial clock output (master) |
| sck_i | input | 1 | Serial clock input (slave) |
| ss_n_o | output | 1 | Active-low select output (master) |
| ss_n_i | input | 1 | Active-low select input (slave) |
| mosi_o | output | 1 | Master data output |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_i | input | 1 | Master data input |

## Verification
The bench builds the block with its default parameters: four frames of up to 32 bits and an 8-bit divider, driven with `half_div`=2. Four frames of 32 bits fill every bit of both buffers. This makes the packing edge at bit 127 reachable, and the 20-, 24- and 11-bit lengths leave gaps that must read as zero. The short divider keeps every transfer within a few hundred cycles, so all length codes, both bit orders, illegal codes and both slave framing modes fit in one run.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_SLAVE
    } xfer_state_t;

    // Frame length in bits for a length code; zero marks an illegal code.
    function automatic logic [5:0] len_of(input logic [3:0] code);
        logic [5:0] n;
        if (code <= 4'd8)        n = 6'd8 + {2'b00, code};
        else if (code == 4'd9)   n = 6'd20;
        else if (code == 4'd10)  n = 6'd24;
        else if (code == 4'd11)  n = 6'd32;
        else                     n = 6'd0;
        return n;
    endfunction

endpackage

// File: rtl/spi_bit_cursor.sv
module spi_bit_cursor #(
    parameter int FRAMES = 4,
    parameter int FW     = 32,
    localparam int FI    = $clog2(FRAMES),
    localparam int BI    = $clog2(FW),
    localparam int LW    = BI + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           adv,
    input  logic [LW-1:0]  len,
    input  logic [FI-1:0]  nfr_m1,
    input  logic           lsb,
    output logic [FI+BI-1:0] idx,
    output logic           last
);
    logic [BI-1:0] bit_q;
    logic [FI-1:0] frm_q;
    logic [BI-1:0] top;
    logic [BI-1:0] pos;
    logic          frame_end;

    always_comb begin
        top       = BI'(len - LW'(1));
        frame_end = (bit_q == top);
        last      = frame_end && (frm_q == nfr_m1);
        pos       = lsb ? bit_q : (top - bit_q);
        idx       = {frm_q, pos};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0;
            frm_q <= '0;
        end else if (clr) begin
            bit_q <= '0;
            frm_q <= '0;
        end else if (adv) begin
            if (frame_end) begin
                bit_q <= '0;
                frm_q <= frm_q + FI'(1);
            end else begin
                bit_q <= bit_q + BI'(1);
            end
        end
    end

    // R1: the bit counter never passes the end of the selected frame length
    a_r1_bit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= top);

    // R4: the frame counter never passes the programmed frame count
    a_r4_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q <= nfr_m1);

endmodule

// File: rtl/spi_tx_dbuf.sv
module spi_tx_dbuf #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic         full,
    output logic         overrun,
    output logic [W-1:0] act
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            act     <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (wr && full) begin
                overrun <= 1'b1;
            end else if (wr) begin
                hold_q <= wdata;
                full   <= 1'b1;
            end
            if (load) begin
                act  <= hold_q;
                full <= 1'b0;
            end
        end
    end

    // R9: a write into a full holding register leaves it untouched
    a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |=> $stable(hold_q));

    // R9: the overrun flag is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int FRAMES = 4,
    parameter int FW     = 32,
    parameter int DIVW   = 8,
    localparam int BUFW  = FRAMES * FW,
    localparam int FI    = $clog2(FRAMES),
    localparam int BI    = $clog2(FW),
    localparam int LW    = BI + 1,
    localparam int IW    = FI + BI
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_master,
    input  logic            cfg_3wire,
    input  logic            cfg_lsb,
    input  logic [3:0]      cfg_len,
    input  logic [FI-1:0]   cfg_nfr,
    input  logic [DIVW-1:0] half_div,
    input  logic            tx_wr,
    input  logic [BUFW-1:0] tx_data,
    input  logic            start,
    output logic            tx_overrun,
    output logic [BUFW-1:0] rx_data,
    output logic            done,
    output logic            sck_o,
    input  logic            sck_i,
    output logic            ss_n_o,
    input  logic            ss_n_i,
    output logic            mosi_o,
    input  logic            mosi_i,
    output logic            miso_o,
    input  logic            miso_i
);
    xfer_state_t st_q, st_d;

    logic            m_q, w3_q, lsb_q;
    logic [LW-1:0]   len_q, len_in;
    logic [FI-1:0]   nfr_q;
    logic [DIVW-1:0] div_q;
    logic            tick;
    logic [2:0]      sck_sy;
    logic [1:0]      ss_sy, mo_sy;
    logic            s_rise, s_fall, s_en;
    logic            go, samp, adv, fin, last, tx_full, tx_bit, sin;
    logic [IW-1:0]   idx;
    logic [BUFW-1:0] tx_act, rx_sh, rx_nx;

    spi_bit_cursor #(.FRAMES(FRAMES), .FW(FW)) u_cursor (
        .clk(clk), .rst_n(rst_n), .clr(go), .adv(adv),
        .len(len_q), .nfr_m1(nfr_q), .lsb(lsb_q),
        .idx(idx), .last(last)
    );

    spi_tx_dbuf #(.W(BUFW)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_data),
        .load(go), .full(tx_full), .overrun(tx_overrun), .act(tx_act)
    );

    // Control strobes
    always_comb begin
        len_in = LW'(len_of(cfg_len));
        tick   = (div_q == half_div);
        s_rise = sck_sy[1] && !sck_sy[2];
        s_fall = !sck_sy[1] && sck_sy[2];
        s_en   = w3_q || !ss_sy[1];
        go     = start && (st_q == ST_IDLE) && tx_full && (len_in != '0);
        samp   = (tick && (st_q == ST_LEAD || st_q == ST_LOW))
              || (st_q == ST_SLAVE && s_rise && s_en);
        adv    = (st_q == ST_HIGH && tick && !last)
              || (st_q == ST_SLAVE && s_fall && s_en);
        fin    = (st_q == ST_TRAIL && tick)
              || (st_q == ST_SLAVE && s_rise && s_en && last);
        tx_bit = tx_act[idx];
        sin    = m_q ? miso_i : mo_sy[1];
        rx_nx  = rx_sh;
        if (samp) rx_nx[idx] = sin;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = cfg_master ? ST_LEAD : ST_SLAVE;
            ST_LEAD:  if (tick) st_d = ST_HIGH;
            ST_HIGH:  if (tick) st_d = last ? ST_TRAIL : ST_LOW;
            ST_LOW:   if (tick) st_d = ST_HIGH;
            ST_TRAIL: if (tick) st_d = ST_IDLE;
            ST_SLAVE: if (fin) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sy  <= '0;
            ss_sy   <= '1;
            mo_sy   <= '0;
            div_q   <= '0;
            m_q     <= 1'b0;
            w3_q    <= 1'b0;
            lsb_q   <= 1'b0;
            len_q   <= '0;
            nfr_q   <= '0;
            rx_sh   <= '0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            sck_sy <= {sck_sy[1:0], sck_i};
            ss_sy  <= {ss_sy[0], ss_n_i};
            mo_sy  <= {mo_sy[0], mosi_i};
            if (st_q == ST_IDLE || tick) div_q <= '0;
            else                         div_q <= div_q + DIVW'(1);
            if (go) begin
                m_q   <= cfg_master;
                w3_q  <= cfg_3wire;
                lsb_q <= cfg_lsb;
                len_q <= len_in;
                nfr_q <= cfg_nfr;
                rx_sh <= '0;
            end else begin
                rx_sh <= rx_nx;
            end
            if (fin) rx_data <= rx_nx;
            done <= fin;
        end
    end

    // Pin outputs
    always_comb begin
        sck_o  = 1'b0;
        ss_n_o = 1'b1;
        mosi_o = 1'b0;
        miso_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LEAD, ST_LOW, ST_TRAIL: begin
                ss_n_o = w3_q;
                mosi_o = tx_bit;
            end
            ST_HIGH: begin
                sck_o  = 1'b1;
                ss_n_o = w3_q;
                mosi_o = tx_bit;
            end
            ST_SLAVE: miso_o = tx_bit;
            default: ;
        endcase
    end

    // R6: in four-wire master mode the select is low whenever the clock is high
    a_r6_ss_covers_sck: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && !w3_q) |-> !ss_n_o);

    // R6: three-wire transfers never drive the select low
    a_r6_three_wire_no_ss: assert property (@(posedge clk) disable iff (!rst_n)
        (w3_q && st_q != ST_IDLE) |-> ss_n_o);

    // R5: master data holds steady while the clock is high
    a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && !tick) |=> $stable(mosi_o));

    // R8: done lasts one cycle and the select is already released
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_ss_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ss_n_o);

    // R1: an active transfer always carries a legal length
    a_r1_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (len_q != '0));

endmodule

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_master = 1'b1, cfg_3wire = 1'b0, cfg_lsb = 1'b0;
    logic [3:0]   cfg_len = 4'd0;
    logic [1:0]   cfg_nfr = 2'd0;
    logic [7:0]   half_div = 8'd2;
    logic         tx_wr = 1'b0, start = 1'b0;
    logic [127:0] tx_data = '0;
    logic         tx_overrun, done, sck_o, ss_n_o, mosi_o, miso_o;
    logic [127:0] rx_data;
    logic         sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic         miso_i;

    int nchk = 0, nfail = 0;
    int nbits = 0;
    logic exp_bits [0:127];
    logic drv_bits [0:127];
    logic got_bits [0:127];
    logic [127:0] exp_rx;
    int   ncap;
    int   ss_bad;
    int   ss_low_seen;
    logic cap_en = 1'b0, cap_clr = 1'b0;
    realtime t_r0, t_r1;

    always #4 clk = ~clk;

    spi_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_3wire(cfg_3wire),
        .cfg_lsb(cfg_lsb), .cfg_len(cfg_len), .cfg_nfr(cfg_nfr), .half_div(half_div),
        .tx_wr(tx_wr), .tx_data(tx_data), .start(start), .tx_overrun(tx_overrun),
        .rx_data(rx_data), .done(done), .sck_o(sck_o), .sck_i(sck_i),
        .ss_n_o(ss_n_o), .ss_n_i(ss_n_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i)
    );

    // Bench-side slave model for master tests: next bit presented after each sample
    assign miso_i = (ncap < 128) ? drv_bits[ncap[6:0]] : 1'b0;

    always @(posedge sck_o or posedge cap_clr) begin
        if (cap_clr) begin
            ncap   = 0;
            ss_bad = 0;
        end else if (cap_en) begin
            if (ncap < 128) got_bits[ncap] = mosi_o;
            if (ncap == 0) t_r0 = $realtime;
            if (ncap == 1) t_r1 = $realtime;
            if (ss_n_o && !cfg_3wire) ss_bad = ss_bad + 1;
            ncap = ncap + 1;
        end
    end

    always @(negedge ss_n_o or posedge cap_clr) begin
        if (cap_clr) ss_low_seen = 0;
        else         ss_low_seen = ss_low_seen + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int blen(input logic [3:0] c);
        if (c <= 4'd8) return 8 + int'(c);
        if (c == 4'd9) return 20;
        if (c == 4'd10) return 24;
        return 32;
    endfunction

    task automatic build(input logic [3:0] c, input int nfr, input bit lsb,
                         input logic [127:0] tx, input logic [127:0] pat);
        int l;
        l = blen(c);
        nbits = 0;
        exp_rx = '0;
        for (int k = 0; k <= nfr; k++) begin
            for (int j = 0; j < l; j++) begin
                int b;
                b = 32 * k + (lsb ? j : (l - 1 - j));
                exp_bits[nbits] = tx[b];
                drv_bits[nbits] = pat[b];
                exp_rx[b] = pat[b];
                nbits++;
            end
        end
    endtask

    task automatic write_tx(input logic [127:0] d);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_cap();
        cap_clr = 1'b1;
        #1;
        cap_clr = 1'b0;
    endtask

    task automatic wait_done(output bit seen, input int lim);
        seen = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Master transfer with data already in the holding register
    task automatic run_master(input logic [3:0] c, input int nfr, input bit lsb, input bit w3,
                              input logic [127:0] tx, input logic [127:0] pat,
                              input bit mid_wr, input logic [127:0] mid_data, input string tag);
        bit seen;
        int bad;
        cfg_master = 1'b1; cfg_3wire = w3; cfg_lsb = lsb; cfg_len = c; cfg_nfr = 2'(nfr);
        build(c, nfr, lsb, tx, pat);
        clear_cap();
        cap_en = 1'b1;
        pulse_start();
        if (mid_wr) begin
            repeat (10) @(negedge clk);
            write_tx(mid_data);
        end
        wait_done(seen, 20000);
        cap_en = 1'b0;
        chk(seen, {tag, " R8 done pulse"}, 128'(seen), 128'(1));
        chk(ncap == nbits, {tag, " R4 rising edge count"}, 128'(ncap), 128'(nbits));
        bad = 0;
        for (int s = 0; s < nbits; s++) if (got_bits[s] !== exp_bits[s]) bad++;
        chk(bad == 0, {tag, " R2 R3 mosi bit stream errors"}, 128'(bad), 128'(0));
        chk(rx_data === exp_rx, {tag, " R2 R8 rx_data"}, rx_data, exp_rx);
        chk(ss_bad == 0, {tag, " R6 select low at every edge"}, 128'(ss_bad), 128'(0));
        chk(ss_n_o === 1'b1 && sck_o === 1'b0, {tag, " R5 R6 idle pins after done"},
            128'({ss_n_o, sck_o}), 128'(2));
        if (w3) chk(ss_low_seen == 0, {tag, " R6 three-wire select stays high"},
                    128'(ss_low_seen), 128'(0));
        @(negedge clk);
        chk(done === 1'b0, {tag, " R8 done one cycle"}, 128'(done), 128'(0));
    endtask

    // Slave transfer, bench acts as master with 6-cycle half periods
    task automatic run_slave(input logic [3:0] c, input int nfr, input bit lsb, input bit w3,
                             input logic [127:0] tx, input logic [127:0] pat, input string tag);
        bit seen;
        int bad;
        cfg_master = 1'b0; cfg_3wire = w3; cfg_lsb = lsb; cfg_len = c; cfg_nfr = 2'(nfr);
        build(c, nfr, lsb, tx, pat);
        write_tx(tx);
        pulse_start();
        ss_n_i = 1'b1;
        if (!w3) begin
            // clock pulses with select high must be ignored
            mosi_i = 1'b1;
            for (int n = 0; n < 3; n++) begin
                repeat (6) @(negedge clk); sck_i = 1'b1;
                repeat (6) @(negedge clk); sck_i = 1'b0;
            end
            repeat (6) @(negedge clk);
            ss_n_i = 1'b0;
        end
        bad = 0;
        seen = 1'b0;
        for (int s = 0; s < nbits; s++) begin
            mosi_i = drv_bits[s];
            repeat (6) @(negedge clk);
            if (miso_o !== exp_bits[s]) bad++;
            sck_i = 1'b1;
            if (s == nbits - 1) begin
                wait_done(seen, 20);
            end else begin
                repeat (6) @(negedge clk);
                sck_i = 1'b0;
            end
        end
        chk(seen, {tag, " R7 R8 slave done"}, 128'(seen), 128'(1));
        chk(bad == 0, {tag, " R7 R3 miso bit stream errors"}, 128'(bad), 128'(0));
        chk(rx_data === exp_rx, {tag, " R7 R2 slave rx_data"}, rx_data, exp_rx);
        repeat (6) @(negedge clk);
        sck_i = 1'b0;
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sck_o === 1'b0 && ss_n_o === 1'b1 && done === 1'b0 && tx_overrun === 1'b0,
            "R10 reset pins", 128'({sck_o, ss_n_o, done, tx_overrun}), 128'(4'b0100));
        chk(rx_data === '0, "R10 reset rx_data", rx_data, '0);
    endtask

    task automatic t_ignored_start(input logic [3:0] c, input string tag);
        bit seen;
        cfg_master = 1'b1; cfg_3wire = 1'b0; cfg_len = c; cfg_nfr = 2'd0;
        clear_cap();
        pulse_start();
        wait_done(seen, 300);
        chk(!seen && ss_low_seen == 0 && ncap == 0, tag,
            128'({seen, 8'(ss_low_seen), 8'(ncap)}), 128'(0));
    endtask

    initial begin
        logic [127:0] a, b, cc, d, e, f, g, h, p1, p2;
        a  = 128'h0000_0000_0000_0000_0000_0000_0000_00A5;
        b  = 128'h8123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
        cc = 128'h0000_0000_0000_0000_000C_3A5F_0009_6E1B;
        d  = 128'h0000_0000_00F0_0F3C_0012_34C5_0098_7654;
        e  = 128'h0000_0000_0000_0000_0000_B00D_0000_1234;
        f  = 128'h0000_0000_0000_0000_0000_0000_0000_003C;
        g  = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
        h  = 128'h0000_0000_0000_0000_0000_0555_0000_02AA;
        p1 = 128'h5A5A_C3C3_0FF0_9669_A55A_3CC3_F00F_6996;
        p2 = 128'hFEED_BEEF_1357_9BDF_2468_ACE0_DEAD_C0DE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        // R1 R3 R5: 8-bit frame, MSB first, clock period
        write_tx(a);
        run_master(4'd0, 0, 1'b0, 1'b0, a, p1, 1'b0, '0, "len8 msb");
        chk((t_r1 - t_r0) == 48.0, "R5 sck period 2*(half_div+1) clocks",
            128'(int'(t_r1 - t_r0)), 128'(48));

        // R2 R4: four 32-bit frames LSB first fill the buffers
        write_tx(b);
        run_master(4'd11, 3, 1'b1, 1'b0, b, p2, 1'b0, '0, "4x32 lsb");

        // R9: write during a transfer is accepted, used by the next transfer
        write_tx(cc);
        run_master(4'd9, 1, 1'b0, 1'b0, cc, p1, 1'b1, d, "2x20 msb");
        chk(tx_overrun === 1'b0, "R9 no overrun for write during transfer",
            128'(tx_overrun), 128'(0));
        run_master(4'd10, 2, 1'b1, 1'b0, d, p2, 1'b0, '0, "3x24 lsb");

        // R9: start with empty holding register ignored
        t_ignored_start(4'd0, "R9 start without data ignored");

        // R6: three-wire master keeps select high
        write_tx(e);
        run_master(4'd8, 1, 1'b0, 1'b1, e, p2, 1'b0, '0, "3wire 2x16");

        // R1: illegal length code ignored
        write_tx(f);
        t_ignored_start(4'd12, "R1 illegal code 12 ignored");
        t_ignored_start(4'd15, "R1 illegal code 15 ignored");

        // R9: write into full holding register sets overrun and keeps old data
        write_tx(g);
        chk(tx_overrun === 1'b1, "R9 overrun on write while full", 128'(tx_overrun), 128'(1));
        run_master(4'd0, 0, 1'b0, 1'b0, f, p1, 1'b0, '0, "R9 held data kept");
        chk(tx_overrun === 1'b1, "R9 overrun sticky", 128'(tx_overrun), 128'(1));

        // R7: slave four-wire with ignored clocks, and slave three-wire
        run_slave(4'd3, 1, 1'b0, 1'b0, h, p2, "slave 2x11 msb");
        run_slave(4'd9, 0, 1'b1, 1'b1, b, p1, "slave3w 20 lsb");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        #1_500_000;
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule